// File: doc/BRIEF.md
# SPI Master Byte Transceiver

This block is the shifting core of an SPI master. It runs from the system clock. Writing a byte to the data port starts an eight-bit exchange. The block drives the serial clock `sck`, sends the byte most significant bit first on `sdo`, and captures `sdi` into the same shift register. When the eighth bit finishes, the captured byte goes into the receive buffer `rx_data` and the `done` flag is raised.

Three configuration bits set the serial framing:

- The clock idle level.
- Which half of each bit period carries the active clock level.
- Whether `sdi` is captured in the middle of the bit or at its end.

A two-bit rate code selects one of four bit rates. Three are fixed divisions of the system clock. The fourth is paced by an external timer pulse, with two pulses per bit. A receive-only mode releases `sdo`. In that mode the engine clocks byte after byte without any write, and each byte is flagged like a normal one. The usual use is as a line activity monitor.

A three-state controller sequences each bit:

- `ST_IDLE`: waits for a start.
- `ST_LEAD`: the first half of a bit.
- `ST_TRAIL`: the second half of a bit.

The transitions are:

- *start*, from `ST_IDLE` to `ST_LEAD`, on a write or while receive-only is set.
- *half*, from `ST_LEAD` to `ST_TRAIL`, on a half-bit tick.
- *next*, from `ST_TRAIL` to `ST_LEAD`, on a half-bit tick that ends bits 0 to 6.
- *wrap*, from `ST_TRAIL` to `ST_LEAD`, at the end of bit 7 in receive-only mode.
- *finish*, from `ST_TRAIL` to `ST_IDLE`, at the end of bit 7 otherwise.

Top module: `spi_master_engine`

## Requirements
- R1: A `wr_en` pulse while idle starts a transfer. `busy` is high from the next clock edge until the edge that sets `done` (outside receive-only mode).
- R2: `sdo` carries the written byte most significant bit first, eight bits. Each bit is stable at the mid-bit `sck` edge.
- R3: `cfg_rate` sets the bit period. 0 gives 4 clocks, 1 gives 16 clocks, 2 gives 64 clocks, and 3 gives two `tmr_tick` pulses.
- R4: Whenever `busy` is low, `sck` equals `cfg_pol`. Here 0 means idle low and 1 means idle high.
- R5: `cfg_edge` sets the edge placement within each bit. With 1, `sck` stays idle during the first half, so its edges fall at mid-bit and end of bit, and `sdo` is already valid before the first edge. With 0, `sck` is active during the first half, so its edges fall at the start and middle of the bit.
- R6: `cfg_smp` sets the capture point for `sdi`. With 0, `sdi` is captured at the end of the first half-bit. With 1, it is captured at the end of the bit.
- R7: At the end of the eighth bit, the received byte appears on `rx_data` and `done` goes high. `done` stays high until a `clr_flags` pulse.
- R8: While `cfg_rx_only` is 1, `sdo_oe` and `sdo` are low. The engine starts and repeats transfers with no write, and each completed byte raises `done` again.
- R9: A `wr_en` while busy sets `wcol` on the next edge. The write is otherwise ignored, so the byte in flight is unchanged.
- R10: If a byte completes while the previous one has not been acknowledged with `rd_ack`, `ovf` is set and `rx_data` keeps the earlier byte. `clr_flags` clears `ovf` and `wcol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pol | input | 1 | Serial clock idle level |
| cfg_edge | input | 1 | 1: clock active in second half-bit; 0: in first half-bit |
| cfg_smp | input | 1 | 0: capture sdi mid-bit; 1: capture at bit end |
| cfg_rate | input | 2 | Bit rate code |
| cfg_rx_only | input | 1 | Receive-only continuous mode, sdo released |
| tmr_tick | input | 1 | External timer pulse for rate code 3 |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | W | Byte to send |
| rd_ack | input | 1 | Marks the receive buffer as read |
| clr_flags | input | 1 | Clears done, ovf and wcol |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Byte complete flag |
| ovf | output | 1 | Receive overflow flag |
| wcol | output | 1 | Write collision flag |
| rx_data | output | W | Receive buffer |

## Verification
A bench slave changes `sdi` in the middle of every bit. The first half of each bit carries one byte and the second half carries another. The received value therefore shows directly which capture point `cfg_smp` chose. Every polarity and edge combination is paired with a different rate code and with asymmetric data such as 0x01 and 0xFE. This exposes bit-order errors, a swapped edge placement and a wrong divider. The delay from the write to the first clock edge separates the two edge placements. A collision write in mid-transfer and an unacknowledged receive-only stream cover `wcol`, `ovf` and the preserved buffer.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } eng_state_t;

    localparam logic [1:0] RATE_TMR = 2'd3;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int HALF_FAST = 2,
    parameter int HALF_MID  = 8,
    parameter int HALF_SLOW = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       tmr_tick,
    output logic       half_tick
);
    import spi_eng_pkg::*;

    localparam int CW = $clog2(HALF_SLOW) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        case (rate)
            2'd0:    lim = CW'(HALF_FAST - 1);
            2'd1:    lim = CW'(HALF_MID - 1);
            default: lim = CW'(HALF_SLOW - 1);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign half_tick = run && ((rate == RATE_TMR) ? tmr_tick : (cnt == lim));

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         samp_mid,
    input  logic         shift,
    input  logic         smp_end,
    input  logic         sdi,
    output logic         msb,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] sh;
    logic         samp_q;
    logic         bit_in;

    assign bit_in  = smp_end ? sdi : samp_q;
    assign msb     = sh[W-1];
    assign rx_word = {sh[W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_val;
        end else if (shift) begin
            sh <= {sh[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
        end else if (samp_mid) begin
            samp_q <= sdi;
        end
    end

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         complete,
    input  logic [W-1:0] rx_word,
    input  logic         rd_ack,
    input  logic         clr,
    input  logic         wcol_evt,
    output logic [W-1:0] rx_buf,
    output logic         done,
    output logic         ovf,
    output logic         wcol
);
    logic rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (complete && !rx_full) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_ack) begin
            rx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            ovf  <= 1'b0;
            wcol <= 1'b0;
        end else begin
            if (complete)       done <= 1'b1;
            else if (clr)       done <= 1'b0;
            if (complete && rx_full) ovf <= 1'b1;
            else if (clr)       ovf <= 1'b0;
            if (wcol_evt)       wcol <= 1'b1;
            else if (clr)       wcol <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
    parameter int W         = 8,
    parameter int HALF_FAST = 2,
    parameter int HALF_MID  = 8,
    parameter int HALF_SLOW = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_pol,
    input  logic         cfg_edge,
    input  logic         cfg_smp,
    input  logic [1:0]   cfg_rate,
    input  logic         cfg_rx_only,
    input  logic         tmr_tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_ack,
    input  logic         clr_flags,
    input  logic         sdi,
    output logic         sck,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         busy,
    output logic         done,
    output logic         ovf,
    output logic         wcol,
    output logic [W-1:0] rx_data
);
    import spi_eng_pkg::*;

    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    eng_state_t    state, state_nx;
    logic [BW-1:0] bit_cnt;
    logic          half_tick;
    logic          start, samp_mid, shift, last, load;
    logic [W-1:0]  load_val;
    logic          msb;
    logic [W-1:0]  rx_word;

    assign start    = (state == ST_IDLE) && (wr_en || cfg_rx_only);
    assign samp_mid = (state == ST_LEAD) && half_tick;
    assign shift    = (state == ST_TRAIL) && half_tick;
    assign last     = shift && (bit_cnt == LAST_BIT);
    assign load     = start || (last && cfg_rx_only);
    assign load_val = (start && wr_en) ? wr_data : '0;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_LEAD;
            ST_LEAD:  if (half_tick) state_nx = ST_TRAIL;
            ST_TRAIL: begin
                if (half_tick) begin
                    if (bit_cnt != LAST_BIT) state_nx = ST_LEAD;
                    else if (cfg_rx_only)    state_nx = ST_LEAD;
                    else                     state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (load)       bit_cnt <= '0;
            else if (shift) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        logic active;
        busy   = (state != ST_IDLE);
        active = ((state == ST_LEAD) && !cfg_edge) || ((state == ST_TRAIL) && cfg_edge);
        sck    = cfg_pol ^ active;
        sdo_oe = !cfg_rx_only;
        sdo    = sdo_oe & msb;
    end

    spi_rate_gen #(
        .HALF_FAST(HALF_FAST),
        .HALF_MID (HALF_MID),
        .HALF_SLOW(HALF_SLOW)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .rate     (cfg_rate),
        .tmr_tick (tmr_tick),
        .half_tick(half_tick)
    );

    spi_shift_unit #(.W(W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .samp_mid(samp_mid),
        .shift   (shift),
        .smp_end (cfg_smp),
        .sdi     (sdi),
        .msb     (msb),
        .rx_word (rx_word)
    );

    spi_flag_unit #(.W(W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .complete(last),
        .rx_word (rx_word),
        .rd_ack  (rd_ack),
        .clr     (clr_flags),
        .wcol_evt(wr_en && busy),
        .rx_buf  (rx_data),
        .done    (done),
        .ovf     (ovf),
        .wcol    (wcol)
    );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_pol,
    input logic         wr_en,
    input logic         clr_flags,
    input logic         sck,
    input logic         busy,
    input logic         done,
    input logic         ovf,
    input logic         wcol,
    input logic [W-1:0] rx_data
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> busy); // R1
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cfg_pol)); // R4
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_flags) |=> done); // R7
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> wcol); // R9
    AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $stable(rx_data)); // R10
endmodule

bind spi_master_engine spi_eng_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_pol  (cfg_pol),
    .wr_en    (wr_en),
    .clr_flags(clr_flags),
    .sck      (sck),
    .busy     (busy),
    .done     (done),
    .ovf      (ovf),
    .wcol     (wcol),
    .rx_data  (rx_data)
);

// File: tb/test_spi_master_engine.sv
module test_spi_master_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pol = 1'b0, cfg_edge = 1'b0, cfg_smp = 1'b0, cfg_rx_only = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic       tmr_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_ack = 1'b0, clr_flags = 1'b0;
    logic       sdi = 1'b0;
    logic       sck, sdo, sdo_oe, busy, done, ovf, wcol;
    logic [7:0] rx_data;

    int n_chk = 0, n_err = 0, mon_cnt = 0;
    bit finished = 0;
    int exp_rx[$];
    int exp_tx[$];

    bit         run = 0;
    int         ecnt = 0;
    logic [7:0] sa = 0, sb = 0, tx_cap = 0;
    realtime    t_first = 0, t_mid0 = 0, t_mid1 = 0;
    int         tick_div = 0;

    always #2 clk = ~clk;

    spi_master_engine i_spi_master_engine (
        .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_edge(cfg_edge),
        .cfg_smp(cfg_smp), .cfg_rate(cfg_rate), .cfg_rx_only(cfg_rx_only),
        .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data), .rd_ack(rd_ack),
        .clr_flags(clr_flags), .sdi(sdi), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe),
        .busy(busy), .done(done), .ovf(ovf), .wcol(wcol), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // timer pulse every third clock
    always @(negedge clk) begin
        tick_div = (tick_div == 2) ? 0 : tick_div + 1;
        tmr_tick = (tick_div == 0);
    end

    // slave model: sdi carries sa in first half-bit, sb in second half-bit
    always @(sck) begin
        if (run) begin
            int  k;
            bit  mid;
            mid = cfg_edge ? (ecnt % 2 == 0) : (ecnt % 2 == 1);
            if (ecnt == 0) t_first = $realtime;
            if (mid) begin
                k = (ecnt / 2) % 8;
                tx_cap[7-k] = sdo;
                sdi = sb[7-k];
                if (k == 0) t_mid0 = $realtime;
                if (k == 1) t_mid1 = $realtime;
            end else begin
                k = cfg_edge ? ((ecnt + 1) / 2) % 8 : (ecnt / 2) % 8;
                sdi = sa[7-k];
            end
            ecnt++;
        end
    end

    // scoreboard monitor
    always begin
        int er, et;
        @(posedge done);
        @(negedge clk);
        if (exp_rx.size() > 0) begin
            er = exp_rx.pop_front();
            et = exp_tx.pop_front();
            chk(rx_data == er[7:0], "R6 R7 received byte", rx_data, er);
            if (et >= 0) chk(tx_cap == et[7:0], "R2 sent byte", tx_cap, et);
        end else begin
            chk(0, "R7 unexpected completion", rx_data, 0);
        end
        mon_cnt++;
    end

    task automatic wait_mon(input int target);
        for (int i = 0; i < 20000 && mon_cnt < target; i++) @(negedge clk);
        chk(mon_cnt >= target, "R7 completion seen", mon_cnt, target);
    endtask

    task automatic ack();
        @(negedge clk); rd_ack = 1; clr_flags = 1;
        @(negedge clk); rd_ack = 0; clr_flags = 0;
    endtask

    task automatic set_cfg(input bit p, input bit e, input bit s, input logic [1:0] r);
        @(negedge clk);
        run = 0; cfg_pol = p; cfg_edge = e; cfg_smp = s; cfg_rate = r;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] a, input logic [7:0] b,
                        input int period, input int first_ns, input bit collide);
        int n0;
        realtime t0;
        @(negedge clk);
        ecnt = 0; sa = a; sb = b; sdi = a[7]; tx_cap = 0; run = 1;
        exp_rx.push_back(cfg_smp ? b : a);
        exp_tx.push_back(tx);
        n0 = mon_cnt;
        wr_en = 1; wr_data = tx; t0 = $realtime;
        @(negedge clk); wr_en = 0;
        chk(busy == 1, "R1 busy after write", busy, 1);
        if (collide) begin
            repeat (3) @(negedge clk);
            wr_en = 1; wr_data = ~tx;
            @(negedge clk); wr_en = 0;
            chk(wcol == 1, "R9 collision flag", wcol, 1);
        end
        wait_mon(n0 + 1);
        chk(busy == 0, "R1 busy low at done", busy, 0);
        chk(done == 1, "R7 done held", done, 1);
        chk(sck == cfg_pol, "R4 idle level", sck, cfg_pol);
        chk(int'((t_mid1 - t_mid0) / 4.0) == period, "R3 bit period", int'((t_mid1 - t_mid0) / 4.0), period);
        if (first_ns >= 0)
            chk(int'(t_first - t0) == first_ns, "R5 first edge delay", int'(t_first - t0), first_ns);
        ack();
        chk(done == 0 && wcol == 0, "R7 flags cleared", {done, wcol}, 0);
        run = 0;
    endtask

    initial begin
        #40000000;
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && ovf == 0 && wcol == 0, "R1 R7 reset flags", {busy, done, ovf, wcol}, 0);
        chk(sck == 0 && sdo_oe == 1, "R4 reset sck", {sck, sdo_oe}, 2'b01);
        chk(rx_data == 0, "R7 reset buffer", rx_data, 0);

        set_cfg(0, 1, 0, 2'd0); xfer(8'hA5, 8'h3C, 8'hC3, 4, 10, 0);
        set_cfg(1, 0, 1, 2'd1); xfer(8'h96, 8'h0F, 8'hF0, 16, 2, 0);
        set_cfg(0, 0, 0, 2'd2); xfer(8'h01, 8'h80, 8'h7E, 64, 2, 0);
        set_cfg(1, 1, 1, 2'd3); xfer(8'hFE, 8'h55, 8'hAA, 6, -1, 0);
        set_cfg(0, 1, 1, 2'd0); xfer(8'h5A, 8'h11, 8'hE7, 4, 10, 1);

        // R8 R10: receive-only stream without acknowledgement
        set_cfg(0, 0, 0, 2'd0);
        @(negedge clk);
        ecnt = 0; sa = 8'hC9; sb = 8'h36; sdi = 1'b1; run = 1;
        exp_rx.push_back(8'hC9); exp_tx.push_back(-1);
        n0 = mon_cnt;
        cfg_rx_only = 1;
        @(negedge clk);
        chk(sdo_oe == 0 && sdo == 0, "R8 sdo released", {sdo_oe, sdo}, 0);
        chk(busy == 1, "R8 starts without write", busy, 1);
        wait_mon(n0 + 1);
        for (int i = 0; i < 200 && !ovf; i++) @(negedge clk);
        chk(ovf == 1, "R10 overflow flag", ovf, 1);
        chk(rx_data == 8'hC9, "R10 buffer kept", rx_data, 8'hC9);
        chk(busy == 1, "R8 keeps clocking", busy, 1);
        cfg_rx_only = 0;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        ack();
        chk(ovf == 0 && done == 0, "R10 flags cleared", {ovf, done}, 0);
        run = 0;

        // R8: acknowledged stream, each byte flagged
        set_cfg(1, 1, 1, 2'd0);
        @(negedge clk);
        ecnt = 0; sa = 8'h0F; sb = 8'h6B; sdi = 1'b0; run = 1;
        for (int i = 0; i < 3; i++) begin exp_rx.push_back(8'h6B); exp_tx.push_back(-1); end
        n0 = mon_cnt;
        cfg_rx_only = 1;
        wait_mon(n0 + 1); ack();
        wait_mon(n0 + 2); cfg_rx_only = 0; ack();
        wait_mon(n0 + 3);
        chk(ovf == 0, "R8 no overflow when acknowledged", ovf, 0);
        ack();
        run = 0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule